// File: doc/BRIEF.md
# I2C Register-Pointer Target

This block is an I2C bus target that answers one fixed 7-bit bus address and exposes a 64-byte register space. It works in the style of a real-time-clock chip. The block runs on a system clock that is fast compared with the bus. SCL and SDA pass through a two-flop synchroniser, and the block finds bus edges and START and STOP conditions on the synchronised copies. The block drives SDA only as an open-drain pull-down enable. It never drives SCL.

A write transaction selects where access begins. The first data byte after the address loads a persistent register pointer. Every later byte is stored at the pointer, and the pointer then advances. A read streams bytes out, starting at the pointer and advancing after each byte, for as long as the controller acknowledges. The pointer keeps its value across transactions and wraps from the top of the space back to zero. A random read is therefore a write that carries only the pointer, then a repeated START, then a read. A local port lets the registers be read and preloaded directly.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset, sda_oe_o is low (SDA released) and every register reads 0x00 through the local port.
- R2: An address byte whose upper seven bits equal 7'h68 is acknowledged: the block pulls SDA low during the ninth clock. Bit 0 selects the direction, so 0xD0 means write and 0xD1 means read.
- R3: In a write transaction, every data byte received is acknowledged with SDA low during its ninth clock.
- R4: The first data byte of a write transaction loads the pointer from its low six bits; the upper two bits are ignored. Each later data byte is stored at the pointer, and the pointer then increments.
- R5: The pointer is six bits wide. It wraps from 0x3F to 0x00 both while writing and while reading.
- R6: A read starts at the current pointer value. That value persists across STOP and across transactions that only set the pointer.
- R7: After each byte sent, the pointer increments. A controller ACK (SDA low on the ninth clock) makes the block send the next byte. A NACK (SDA high) ends the transfer, and SDA stays released until the next START or STOP.
- R8: A repeated START, with no STOP before it, begins a new address phase. A pointer write followed by a repeated START and a read address returns the register at the new pointer.
- R9: When the address does not match, the block never pulls SDA. Every byte up to the next START or STOP is neither acknowledged nor stored, and the pointer is left unchanged.
- R10: sda_oe_o changes only while SCL is low.
- R11: loc_rdata_o shows the register at loc_addr_i without any clock delay. A pulse on loc_we_i stores loc_wdata_i at loc_addr_i. When the bus and the local port write in the same cycle, the bus write takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | When high, the block pulls SDA low |
| loc_we_i | input | 1 | Local register write strobe |
| loc_addr_i | input | 6 | Local register address |
| loc_wdata_i | input | 8 | Local register write data |
| loc_rdata_o | output | 8 | Local register read data, combinational |

## Verification
The bench builds the block with its default parameters: bus address 7'h68, a six-bit pointer (64 registers) and two synchroniser stages. At that size, a write that starts at 0x3E crosses the wrap point in three bytes, and a random read from 0x3F shows the read wrap. The bench checks address decode, the pointer load, the persistence of the pointer between transactions, repeated START, the NACK ending, and the silence after a mismatched address. A monitor at the pins watches every change of the SDA enable against the SCL level.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_SKIP
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_hi_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  // [STAGES-1] is the synchronised level, [STAGES] its previous sample
  logic [STAGES:0] scl_sr, sda_sr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
    end else begin
      scl_sr <= {scl_sr[STAGES-1:0], scl_i};
      sda_sr <= {sda_sr[STAGES-1:0], sda_i};
    end
  end

  logic scl_c, scl_p, sda_c, sda_p;
  assign scl_c = scl_sr[STAGES-1];
  assign scl_p = scl_sr[STAGES];
  assign sda_c = sda_sr[STAGES-1];
  assign sda_p = sda_sr[STAGES];

  assign scl_hi_o   = scl_c;
  assign sda_o      = sda_c;
  assign scl_rise_o = scl_c & ~scl_p;
  assign scl_fall_o = ~scl_c & scl_p;
  assign start_o    = scl_c & scl_p & sda_p & ~sda_c;
  assign stop_o     = scl_c & scl_p & ~sda_p & sda_c;
endmodule

// File: rtl/i2c_tgt_regfile.sv
module i2c_tgt_regfile #(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 8,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  input  logic          loc_we_i,
  input  logic [AW-1:0] loc_addr_i,
  input  logic [DW-1:0] loc_wdata_i,
  output logic [DW-1:0] loc_rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (bus_we_i) begin
      mem_q[bus_addr_i] <= bus_wdata_i;
    end else if (loc_we_i) begin
      mem_q[loc_addr_i] <= loc_wdata_i;
    end
  end

  assign bus_rdata_o = mem_q[bus_addr_i];
  assign loc_rdata_o = mem_q[loc_addr_i];

  // R11
  loc_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc_we_i && !bus_we_i) |=>
      (loc_addr_i != $past(loc_addr_i) || loc_rdata_o == $past(loc_wdata_i)));
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h68,
  parameter int unsigned AW       = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_hi_i,
  input  logic          sda_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [7:0]    rd_data_i,
  output logic [AW-1:0] ptr_o,
  output logic          wr_en_o,
  output logic [7:0]    wr_data_o,
  output logic          sda_oe_o
);
  tgt_state_e    state_q;
  logic [3:0]    bit_cnt_q;
  logic [7:0]    rx_q, tx_q;
  logic [AW-1:0] ptr_q;
  logic          need_ptr_q, is_read_q, nack_q, oe_q;

  logic byte_done;
  assign byte_done = scl_fall_i && (bit_cnt_q == 4'd8);

  assign wr_en_o   = !start_i && !stop_i && state_q == ST_WR && byte_done && !need_ptr_q;
  assign wr_data_o = rx_q;
  assign ptr_o     = ptr_q;
  assign sda_oe_o  = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bit_cnt_q  <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      ptr_q      <= '0;
      need_ptr_q <= 1'b0;
      is_read_q  <= 1'b0;
      nack_q     <= 1'b0;
      oe_q       <= 1'b0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else if (start_i) begin
      state_q   <= ST_ADDR;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise_i) begin
            rx_q      <= {rx_q[6:0], sda_i};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (byte_done) begin
            if (rx_q[7:1] == DEV_ADDR) begin
              state_q    <= ST_ADDR_ACK;
              oe_q       <= 1'b1;
              is_read_q  <= rx_q[0];
              need_ptr_q <= 1'b1;
            end else begin
              state_q <= ST_SKIP;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall_i) begin
            bit_cnt_q <= '0;
            if (is_read_q) begin
              tx_q    <= rd_data_i;
              oe_q    <= ~rd_data_i[7];
              state_q <= ST_RD;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_WR;
            end
          end
        end
        ST_WR: begin
          if (scl_rise_i) begin
            rx_q      <= {rx_q[6:0], sda_i};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (byte_done) begin
            oe_q    <= 1'b1;
            state_q <= ST_WR_ACK;
            if (need_ptr_q) begin
              ptr_q      <= rx_q[AW-1:0];
              need_ptr_q <= 1'b0;
            end else begin
              ptr_q <= ptr_q + 1'b1;
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall_i) begin
            oe_q      <= 1'b0;
            bit_cnt_q <= '0;
            state_q   <= ST_WR;
          end
        end
        ST_RD: begin
          if (scl_rise_i) begin
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (byte_done) begin
            oe_q    <= 1'b0;
            ptr_q   <= ptr_q + 1'b1;
            state_q <= ST_RD_ACK;
          end else if (scl_fall_i) begin
            tx_q <= {tx_q[6:0], 1'b0};
            oe_q <= ~tx_q[6];
          end
        end
        ST_RD_ACK: begin
          if (scl_rise_i) begin
            nack_q <= sda_i;
          end else if (scl_fall_i) begin
            if (nack_q) begin
              state_q <= ST_SKIP;
              oe_q    <= 1'b0;
            end else begin
              tx_q      <= rd_data_i;
              oe_q      <= ~rd_data_i[7];
              bit_cnt_q <= '0;
              state_q   <= ST_RD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R10
  oe_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_hi_i && $past(scl_hi_i) && !$past(start_i) && !$past(stop_i)) |-> $stable(oe_q));

  // R9
  skip_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SKIP || state_q == ST_IDLE) |-> !oe_q);

  // R4
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> ptr_q == $past(ptr_q) + AW'(1));

  // R7
  rd_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD && byte_done && !start_i && !stop_i) |=>
      (state_q == ST_RD_ACK && !oe_q));

  // R8
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_q == ST_ADDR && bit_cnt_q == 4'd0 && !oe_q));
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
  parameter logic [6:0]  DEV_ADDR    = 7'h68,
  parameter int unsigned REG_AW      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              loc_we_i,
  input  logic [REG_AW-1:0] loc_addr_i,
  input  logic [7:0]        loc_wdata_i,
  output logic [7:0]        loc_rdata_o
);
  logic scl_hi, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [REG_AW-1:0] ptr;
  logic       bus_we;
  logic [7:0] bus_wdata, bus_rdata;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_hi_o   (scl_hi),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_tgt_fsm #(.DEV_ADDR(DEV_ADDR), .AW(REG_AW)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_hi_i   (scl_hi),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .rd_data_i  (bus_rdata),
    .ptr_o      (ptr),
    .wr_en_o    (bus_we),
    .wr_data_o  (bus_wdata),
    .sda_oe_o   (sda_oe_o)
  );

  i2c_tgt_regfile #(.AW(REG_AW), .DW(8)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_we_i    (bus_we),
    .bus_addr_i  (ptr),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .loc_we_i    (loc_we_i),
    .loc_addr_i  (loc_addr_i),
    .loc_wdata_i (loc_wdata_i),
    .loc_rdata_o (loc_rdata_o)
  );
endmodule

// File: tb/i2c_reg_target_bench.sv
`timescale 1ns/1ps
module i2c_reg_target_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam int QTR  = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda_lo = 1'b0;
  logic       sda_oe;
  logic       sda_line;
  logic       loc_we = 1'b0;
  logic [5:0] loc_addr = '0;
  logic [7:0] loc_wdata = '0;
  logic [7:0] loc_rdata;

  int checks = 0;
  int errors = 0;
  int oe_viol = 0;
  bit done = 0;
  logic oe_p = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_line = !(m_sda_lo || sda_oe);

  i2c_reg_target u_i2c_reg_target (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .scl_i       (m_scl),
    .sda_i       (sda_line),
    .sda_oe_o    (sda_oe),
    .loc_we_i    (loc_we),
    .loc_addr_i  (loc_addr),
    .loc_wdata_i (loc_wdata),
    .loc_rdata_o (loc_rdata)
  );

  // pin monitor for R10
  always @(negedge clk) begin
    if (rst_n && sda_oe !== oe_p && m_scl) oe_viol++;
    oe_p <= sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    tick(QTR); m_sda_lo = !b;
    tick(HALF - QTR); m_scl = 1'b1;
    tick(HALF); m_scl = 1'b0;
  endtask

  task automatic recv_bit(output logic b);
    tick(QTR); m_sda_lo = 1'b0;
    tick(HALF - QTR); m_scl = 1'b1;
    tick(QTR); b = sda_line;
    tick(HALF - QTR); m_scl = 1'b0;
  endtask

  task automatic bus_start();
    m_sda_lo = 1'b1;
    tick(HALF); m_scl = 1'b0;
  endtask

  task automatic bus_rstart();
    tick(QTR); m_sda_lo = 1'b0;
    tick(HALF - QTR); m_scl = 1'b1;
    tick(HALF); m_sda_lo = 1'b1;
    tick(HALF); m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    tick(QTR); m_sda_lo = 1'b1;
    tick(HALF - QTR); m_scl = 1'b1;
    tick(HALF); m_sda_lo = 1'b0;
    tick(HALF);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(a);
    acked = !a;
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(!m_ack);
  endtask

  task automatic loc_write(input logic [5:0] a, input logic [7:0] d);
    loc_addr = a; loc_wdata = d; loc_we = 1'b1;
    tick(1);
    loc_we = 1'b0;
  endtask

  task automatic loc_read(input logic [5:0] a, output logic [7:0] d);
    loc_addr = a;
    tick(1);
    d = loc_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 sda_oe after reset", sda_oe, 1'b0);
    loc_read(6'h00, d); chk("R1 reg 0x00 after reset", d, 8'h00);
    loc_read(6'h3F, d); chk("R1 reg 0x3F after reset", d, 8'h00);
  endtask

  task automatic t_local();
    logic [7:0] d;
    loc_write(6'h01, 8'h5A);
    loc_write(6'h02, 8'hC3);
    loc_write(6'h20, 8'h99);
    loc_read(6'h01, d); chk("R11 local write/read 0x01", d, 8'h5A);
    loc_read(6'h20, d); chk("R11 local write/read 0x20", d, 8'h99);
  endtask

  task automatic t_write();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(8'hD0, a); chk("R2 ack write address", a, 1'b1);
    send_byte(8'h10, a); chk("R3 ack pointer byte", a, 1'b1);
    send_byte(8'hA1, a); chk("R3 ack data byte 1", a, 1'b1);
    send_byte(8'hA2, a); chk("R3 ack data byte 2", a, 1'b1);
    send_byte(8'hA3, a); chk("R3 ack data byte 3", a, 1'b1);
    bus_stop();
    loc_read(6'h10, d); chk("R4 stored at 0x10", d, 8'hA1);
    loc_read(6'h11, d); chk("R4 stored at 0x11", d, 8'hA2);
    loc_read(6'h12, d); chk("R4 stored at 0x12", d, 8'hA3);
    loc_read(6'h13, d); chk("R4 0x13 untouched", d, 8'h00);
  endtask

  task automatic t_wrap_write();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(8'hD0, a);
    send_byte(8'h3E, a);
    send_byte(8'h11, a);
    send_byte(8'h22, a);
    send_byte(8'h33, a); chk("R3 ack after wrap", a, 1'b1);
    bus_stop();
    loc_read(6'h3E, d); chk("R5 write at 0x3E", d, 8'h11);
    loc_read(6'h3F, d); chk("R5 write at 0x3F", d, 8'h22);
    loc_read(6'h00, d); chk("R5 write wrapped to 0x00", d, 8'h33);
  endtask

  task automatic t_cur_read();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(8'hD1, a); chk("R2 ack read address", a, 1'b1);
    recv_byte(1'b1, d); chk("R6 read starts at pointer 0x01", d, 8'h5A);
    recv_byte(1'b0, d); chk("R7 next byte after ack", d, 8'hC3);
    tick(HALF);
    chk("R7 sda released after nack", sda_oe, 1'b0);
    bus_stop();
  endtask

  task automatic t_rand_read();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(8'hD0, a);
    send_byte(8'h3F, a);
    bus_rstart();
    send_byte(8'hD1, a); chk("R8 ack read after repeated start", a, 1'b1);
    recv_byte(1'b1, d); chk("R8 random read at 0x3F", d, 8'h22);
    recv_byte(1'b1, d); chk("R5 read wrapped to 0x00", d, 8'h33);
    recv_byte(1'b0, d); chk("R7 read 0x01 then nack", d, 8'h5A);
    bus_stop();
  endtask

  task automatic t_wrong_addr();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(8'hA0, a); chk("R9 no ack for foreign address", a, 1'b0);
    send_byte(8'h05, a); chk("R9 no ack for ignored byte 1", a, 1'b0);
    send_byte(8'h77, a); chk("R9 no ack for ignored byte 2", a, 1'b0);
    bus_stop();
    loc_read(6'h05, d); chk("R9 0x05 not written", d, 8'h00);
    loc_read(6'h37, d); chk("R9 0x37 not written", d, 8'h00);
    bus_start();
    send_byte(8'hD1, a);
    recv_byte(1'b0, d); chk("R9 pointer unchanged (0x02)", d, 8'hC3);
    bus_stop();
  endtask

  task automatic t_ptr_only();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(8'hD0, a);
    send_byte(8'h60, a); chk("R4 ack pointer 0x60", a, 1'b1);
    bus_stop();
    bus_start();
    send_byte(8'hD1, a);
    recv_byte(1'b0, d); chk("R6 pointer kept across stop, low bits 0x20", d, 8'h99);
    bus_stop();
    loc_read(6'h20, d); chk("R4 pointer-only write stores nothing", d, 8'h99);
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_local();
    t_write();
    t_wrap_write();
    t_cur_read();
    t_rand_read();
    t_wrong_addr();
    t_ptr_only();
    chk("R10 sda_oe changes while scl high", oe_viol, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule